// File: doc/BRIEF.md
# Serial Register Access Port with Time Snapshot

This block is the two-wire serial target that sits in front of a real-time clock's register file. A host selects it with a fixed 7-bit device address. It then reads or writes a 16-byte register space through an internal pointer that steps by one after every byte and rolls over from 0Fh to 00h.

In a write transaction, the first byte after the address loads the pointer. Each byte after that is presented on a one-cycle write strobe toward the clock and alarm logic. In a read transaction, bytes are returned starting at the current pointer until the host answers a byte with a NACK.

On every START, including a repeated START, the block raises a snapshot strobe and captures the time-keeping registers into a shadow copy. Reads of those registers are served from the copy, so a multibyte read stays coherent while the live counters keep moving. The remaining registers are read live. SCL and SDA are sampled through a two-stage synchronizer on the system clock. SDA is driven open-drain style, through an enable with a constant low level.

Top module: `serial_reg_port`

## Requirements
- R1: The block answers only the 7-bit address 1101000, sent MSB first and followed by the direction bit (1 = read, 0 = write). A transaction to any other address gets no ACK, never asserts sda_oe and produces no register write.
- R2: After a matching address byte, and after every byte received in a write transaction, the block holds SDA low during the ninth SCL pulse.
- R3: In a write transaction, the first byte after the address loads the pointer from its low 4 bits; its upper 4 bits are ignored. Each later byte produces exactly one single-cycle reg_we_o pulse carrying the pointer as reg_waddr_o and the byte as reg_wdata_o, and the pointer then advances by one.
- R4: A read transaction returns, MSB first, the register selected by the current pointer, and the pointer advances by one after each byte sent.
- R5: The pointer advances from 0Fh to 00h, in both reads and writes.
- R6: Every START or repeated START produces exactly one one-cycle snap_o pulse. At that point registers 00h–06h are captured, and reads of those registers return the captured values even if the live inputs change later in the same transaction.
- R7: Registers 07h–0Fh are read from reg_live_i as they stand when each byte is loaded for sending.
- R8: After the host NACKs a read byte, the block releases SDA and does not drive it again until the next START, however many SCL pulses follow.
- R9: A STOP returns the block to the idle state with SDA released. A repeated START restarts address decoding, so a write that loads the pointer can be followed directly by a read starting from it.
- R10: sda_oe changes only while the synchronized SCL is low.
- R11: After reset sda_oe is 0, no write strobe is issued and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_o | output | 1 | Level driven on SDA when enabled (always 0) |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| reg_live_i | input | 128 | Live register contents, byte n at bits [8n+7:8n] |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_waddr_o | output | 4 | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| snap_o | output | 1 | One-cycle pulse when the time registers are captured |

## Verification
The assertions assume that SCL and SDA change slowly compared with the system clock. Each SCL phase must last several system clocks, so that the synchronized SCL stays low for at least one cycle after the block moves sda_oe. They also assume the host changes SDA while SCL is high only to signal START or STOP. The stimulus holds every SCL phase for 25 system clocks and moves SDA a few cycles after SCL falls. The host model never drives SDA while the block is expected to drive it.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int PTR_W  = 4;
  localparam int NREG   = 1 << PTR_W;
  localparam int NTIME  = 7;
  localparam logic [6:0] DEV_ADDR = 7'b1101000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_RACK,
    ST_SEND,
    ST_MACK
  } port_state_t;

  // pointer step with natural rollover at the top of the space
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic addr_match(input logic [7:0] b);
    return b[7:1] == DEV_ADDR;
  endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_q;
  logic [STAGES:0] sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q[STAGES];
  assign scl_fall  = ~scl_s & scl_q[STAGES];
  assign start_det = scl_s & scl_q[STAGES] & sda_q[STAGES] & ~sda_s;
  assign stop_det  = scl_s & scl_q[STAGES] & ~sda_q[STAGES] & sda_s;
endmodule

// File: rtl/sreg_shadow.sv
module sreg_shadow
  import sreg_pkg::*;
#(
  parameter int NR = NREG,
  parameter int NT = NTIME,
  parameter int AW = PTR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snap,
  input  logic [NR*8-1:0] live,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      rd_data
);
  logic [7:0] copy_q [NT];

  for (genvar i = 0; i < NT; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rst_n)    copy_q[i] <= '0;
      else if (snap) copy_q[i] <= live[i*8 +: 8];
    end
  end

  always_comb begin
    rd_data = live[rd_addr*8 +: 8];
    for (int i = 0; i < NT; i++)
      if (rd_addr == AW'(i)) rd_data = copy_q[i];
  end
endmodule

// File: rtl/sreg_fsm.sv
module sreg_fsm
  import sreg_pkg::*;
#(
  parameter int AW = PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_byte,
  output logic [AW-1:0] ptr,
  output logic          sda_oe,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic          snap,
  output logic          selected
);
  port_state_t st;
  logic [7:0]  sh;
  logic [7:0]  tx;
  logic [3:0]  cnt;
  logic        is_addr, is_read, first_wr, mack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; tx <= '0; cnt <= '0;
      is_addr <= 1'b0; is_read <= 1'b0; first_wr <= 1'b0; mack <= 1'b0;
      ptr <= '0; sda_oe <= 1'b0; we <= 1'b0; waddr <= '0; wdata <= '0;
      snap <= 1'b0; selected <= 1'b0;
    end else begin
      we   <= 1'b0;
      snap <= 1'b0;
      if (start_det) begin
        st <= ST_RECV; cnt <= '0; is_addr <= 1'b1;
        sda_oe <= 1'b0; selected <= 1'b0; snap <= 1'b1;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0; selected <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_RECV: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (is_addr) begin
                if (addr_match(sh)) begin
                  sda_oe <= 1'b1; selected <= 1'b1;
                  is_read <= sh[0]; first_wr <= ~sh[0];
                  st <= ST_RACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st <= ST_RACK;
                if (first_wr) begin
                  ptr <= sh[AW-1:0];
                  first_wr <= 1'b0;
                end else begin
                  we <= 1'b1; waddr <= ptr; wdata <= sh;
                  ptr <= ptr_step(ptr);
                end
              end
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              is_addr <= 1'b0;
              if (is_read) begin
                tx <= rd_byte; sda_oe <= ~rd_byte[7];
                ptr <= ptr_step(ptr); cnt <= 4'd1; st <= ST_SEND;
              end else begin
                sda_oe <= 1'b0; cnt <= '0; st <= ST_RECV;
              end
            end
          end
          ST_SEND: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; st <= ST_MACK;
              end else begin
                tx <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                tx <= rd_byte; sda_oe <= ~rd_byte[7];
                ptr <= ptr_step(ptr); cnt <= 4'd1; st <= ST_SEND;
              end else begin
                st <= ST_IDLE; selected <= 1'b0;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic [NREG*8-1:0] reg_live_i,
  output logic              reg_we_o,
  output logic [PTR_W-1:0]  reg_waddr_o,
  output logic [7:0]        reg_wdata_o,
  output logic              snap_o
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rd_byte;
  logic             selected;

  sreg_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  sreg_shadow #(.NR(NREG), .NT(NTIME), .AW(PTR_W)) shadow_i (
    .clk(clk), .rst_n(rst_n), .snap(snap_o), .live(reg_live_i),
    .rd_addr(ptr), .rd_data(rd_byte)
  );

  sreg_fsm #(.AW(PTR_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .ptr(ptr), .sda_oe(sda_oe), .we(reg_we_o),
    .waddr(reg_waddr_o), .wdata(reg_wdata_o), .snap(snap_o),
    .selected(selected)
  );

  assign sda_o = 1'b0;
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic snap,
  input logic we,
  input logic selected
);
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  a_r6_start_snaps: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> snap);
  a_r6_snap_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    snap |-> $past(start_det));
  a_r1_drive_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> selected);
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !selected));
  a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
endmodule

bind serial_reg_port sreg_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .snap(snap_o), .we(reg_we_o),
  .selected(selected)
);

// File: tb/serial_reg_port_tb_top.sv
module serial_reg_port_tb_top;
  localparam int H = 25;
  localparam logic [6:0] DEV = 7'b1101000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus, sda_o, sda_oe, reg_we_o, snap_o;
  logic [3:0] reg_waddr_o;
  logic [7:0] reg_wdata_o;
  logic [127:0] live;
  logic [7:0] mem [16];
  logic [3:0] wlog_a [32];
  logic [7:0] wlog_d [32];
  int wcnt = 0, snaps = 0, starts = 0, scl_hi_moves = 0, checks = 0, errors = 0;
  logic poke_v = 1'b0; logic [3:0] poke_a; logic [7:0] poke_d;
  logic oe_prev = 1'b0, oe_seen = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~(sda_oe & ~sda_o);

  serial_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_o(sda_o),
    .sda_oe(sda_oe), .reg_live_i(live), .reg_we_o(reg_we_o),
    .reg_waddr_o(reg_waddr_o), .reg_wdata_o(reg_wdata_o), .snap_o(snap_o)
  );

  always_comb for (int i = 0; i < 16; i++) live[i*8 +: 8] = mem[i];

  initial for (int i = 0; i < 16; i++) mem[i] = 8'h40 + 8'(i * 3);

  always @(negedge clk) begin
    if (poke_v) mem[poke_a] <= poke_d;
    if (rst_n && reg_we_o) begin
      mem[reg_waddr_o] <= reg_wdata_o;
      if (wcnt < 32) begin wlog_a[wcnt] <= reg_waddr_o; wlog_d[wcnt] <= reg_wdata_o; end
      wcnt <= wcnt + 1;
    end
    if (rst_n && snap_o) snaps <= snaps + 1;
    if (sda_oe != oe_prev && scl_m) scl_hi_moves <= scl_hi_moves + 1;
    if (sda_oe) oe_seen <= 1'b1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic poke(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); poke_a = a; poke_d = d; poke_v = 1'b1;
    @(posedge clk); poke_v = 1'b0;
  endtask

  task automatic wait_c(input int n); repeat (n) @(posedge clk); endtask

  task automatic i2c_start();
    wait_c(4); sda_m = 1'b1; wait_c(4); scl_m = 1'b1; wait_c(H);
    sda_m = 1'b0; wait_c(H); scl_m = 1'b0;
    starts++;
  endtask

  task automatic i2c_stop();
    wait_c(4); sda_m = 1'b0; wait_c(H); scl_m = 1'b1; wait_c(H);
    sda_m = 1'b1; wait_c(H);
  endtask

  task automatic put_bit(input logic b);
    wait_c(4); sda_m = b; wait_c(H - 4); scl_m = 1'b1; wait_c(H); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wait_c(4); sda_m = 1'b1; wait_c(H - 4); scl_m = 1'b1; wait_c(H / 2);
    @(negedge clk); b = sda_bus; wait_c(H - H / 2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(ack_n);
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); b[i] = x; end
    put_bit(~ack);
  endtask

  // R11, R4: reset state and a read from the reset pointer
  task automatic t_reset();
    logic an; logic [7:0] d;
    @(negedge clk);
    chk("R11 sda_oe after reset", sda_oe, 0);
    chk("R11 no write after reset", reg_we_o, 0);
    i2c_start(); send_byte({DEV, 1'b1}, an);
    chk("R2 addr ack (read)", an, 0);
    recv_byte(1'b0, d); i2c_stop();
    chk("R11 R4 first read from reg 00", d, 8'h40);
  endtask

  // R1: foreign address ignored
  task automatic t_wrong_addr();
    logic an; int w0 = wcnt;
    @(negedge clk); oe_seen = 1'b0;
    i2c_start(); send_byte({7'b1101001, 1'b0}, an);
    chk("R1 no ack foreign addr", an, 1);
    send_byte(8'h03, an); send_byte(8'h5A, an); i2c_stop();
    chk("R1 no drive foreign addr", oe_seen, 0);
    chk("R1 no write foreign addr", wcnt - w0, 0);
  endtask

  // R3, R2: pointer load with upper bits ignored, then writes
  task automatic t_write();
    logic an; int w0 = wcnt;
    i2c_start(); send_byte({DEV, 1'b0}, an);
    send_byte(8'h32, an); chk("R2 ack pointer byte", an, 0);
    send_byte(8'h11, an); chk("R2 ack data byte", an, 0);
    send_byte(8'h22, an); send_byte(8'h33, an); i2c_stop();
    chk("R3 write count", wcnt - w0, 3);
    chk("R3 first addr", wlog_a[w0], 2);
    chk("R3 first data", wlog_d[w0], 8'h11);
    chk("R3 third addr", wlog_a[w0+2], 4);
    chk("R3 third data", wlog_d[w0+2], 8'h33);
  endtask

  // R5: write wrap
  task automatic t_wrap_write();
    logic an; int w0 = wcnt;
    i2c_start(); send_byte({DEV, 1'b0}, an); send_byte(8'h0E, an);
    send_byte(8'hE1, an); send_byte(8'hF2, an); send_byte(8'h03, an); i2c_stop();
    chk("R5 write addr E", wlog_a[w0], 14);
    chk("R5 write addr F", wlog_a[w0+1], 15);
    chk("R5 write wraps to 0", wlog_a[w0+2], 0);
    chk("R5 data at 0", wlog_d[w0+2], 8'h03);
  endtask

  // R9, R4, R5: repeated START read across the wrap
  task automatic t_read_wrap();
    logic an; logic [7:0] d; logic [7:0] e [4];
    e[0] = mem[13]; e[1] = mem[14]; e[2] = mem[15]; e[3] = mem[0];
    i2c_start(); send_byte({DEV, 1'b0}, an); send_byte(8'h0D, an);
    i2c_start(); send_byte({DEV, 1'b1}, an);
    chk("R9 ack after repeated start", an, 0);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k != 3, d);
      chk("R4 R5 sequential read", d, e[k]);
    end
    i2c_stop();
  endtask

  // R6, R7: shadow copy vs live registers
  task automatic t_snapshot();
    logic an; logic [7:0] d;
    poke(5, 8'h55); poke(6, 8'h66); poke(7, 8'h77); poke(8, 8'h88);
    i2c_start(); send_byte({DEV, 1'b0}, an); send_byte(8'h05, an);
    i2c_start(); send_byte({DEV, 1'b1}, an);
    poke(5, 8'hA5); poke(6, 8'hA6); poke(7, 8'hA7); poke(8, 8'hA8);
    recv_byte(1'b1, d); chk("R6 reg5 from snapshot", d, 8'h55);
    recv_byte(1'b1, d); chk("R6 reg6 from snapshot", d, 8'h66);
    recv_byte(1'b1, d); chk("R7 reg7 live", d, 8'hA7);
    recv_byte(1'b0, d); chk("R7 reg8 live", d, 8'hA8);
    i2c_stop();
    i2c_start(); send_byte({DEV, 1'b0}, an); send_byte(8'h05, an);
    i2c_start(); send_byte({DEV, 1'b1}, an);
    recv_byte(1'b0, d); i2c_stop();
    chk("R6 new snapshot on next start", d, 8'hA5);
  endtask

  // R8: no drive after NACK until next START
  task automatic t_nack();
    logic an; logic [7:0] d; logic x;
    i2c_start(); send_byte({DEV, 1'b1}, an);
    recv_byte(1'b0, d);
    @(negedge clk); oe_seen = 1'b0;
    for (int k = 0; k < 9; k++) get_bit(x);
    chk("R8 released after nack", oe_seen, 0);
    i2c_stop();
  endtask

  initial begin
    fork
      begin
        wait_c(5); rst_n = 1'b1; wait_c(5);
        t_reset(); t_wrong_addr(); t_write(); t_wrap_write();
        t_read_wrap(); t_snapshot(); t_nack();
        wait_c(5);
        chk("R6 one snap per start", snaps, starts);
        chk("R10 sda_oe steady while SCL high", scl_hi_moves, 0);
      end
      begin
        wait_c(150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule